// File: doc/BRIEF.md
# Majority Bundling Class Trainer

This block turns a stream of labelled binary sample hypervectors into one binary prototype per class. Every accepted sample adds its set bits to a bank of per-bit counters owned by its class and bumps that class's sample tally. On a finalize pulse the block walks the classes in ascending order and emits one thresholded prototype per cycle, ready to be written into an associative memory by the surrounding logic.

Thresholding is a bitwise majority vote. When a class holds an even number of samples, a fixed per-class pseudo-random pattern is folded in as one extra vote, so exact ties resolve deterministically. All counters saturate instead of wrapping. A clear pulse wipes every tally in one cycle, and samples that name a class that does not exist are discarded and flagged.

Top module: `hdc_class_trainer`

## Requirements
- R1: While rst_n is low at a rising edge, the block goes to its idle state: proto_valid and label_err are 0 and every class tally and bit counter is zero.
- R2: A sample is accepted when smp_valid is 1, smp_label < NCLS, clr is 0 and no emission is running. It adds 1 to that class's sample tally and 1 to each of the class's bit counters whose smp_vec bit is 1.
- R3: For a class with an odd tally n, prototype bit j is 1 exactly when its bit counter c satisfies 2c > n.
- R4: For a class with an even nonzero tally n, prototype bit j is 1 when 2c > n, or when 2c == n and bit j of that class's tie pattern is 1. The tie pattern for class k is TIE_SEED rotated left by k bit positions, where bit 0 is the least significant bit. The default TIE_SEED is 32'h9E3779B9.
- R5: A class with a zero tally is emitted with proto_vec all zeros and proto_empty set to 1. proto_empty is 0 for every other class.
- R6: The sample tally and every bit counter stop at 2^CNT_W-1 and never wrap.
- R7: A finalize pulse accepted while idle starts an emission on the next cycle. proto_valid is then 1 for exactly NCLS consecutive cycles, and proto_class runs 0, 1, …, NCLS-1.
- R8: A sample accepted in the same cycle as the finalize pulse is included in the emitted prototypes.
- R9: While an emission is running, samples and finalize pulses are ignored and leave the class tallies unchanged.
- R10: A sample with smp_valid=1 and smp_label >= NCLS changes no tally and sets label_err. label_err stays set until clr or reset.
- R11: clr zeroes all tallies and counters, clears label_err and aborts any running emission, all within one cycle. A sample in the same cycle as clr is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_label | input | LBL_W | Class of the sample |
| smp_vec | input | DIM | Encoded sample hypervector |
| clr | input | 1 | Zero all class state, clear the error flag, abort emission |
| fin | input | 1 | Start emitting prototypes |
| proto_valid | output | 1 | A prototype is on proto_vec |
| proto_class | output | LBL_W | Class of the emitted prototype |
| proto_vec | output | DIM | Binarized prototype |
| proto_empty | output | 1 | Emitted class had no samples |
| label_err | output | 1 | Sticky: a sample named a nonexistent class |

## Verification
Two pairs of events can land in the same cycle. A sample can arrive together with the finalize pulse, and a sample can arrive together with clear. The bench provokes the first by driving a class-4 sample in the finalize cycle. It judges the result by checking that class 4 is emitted with that sample's bits rather than as empty. For the second, it drives a sample and clr together, then finalizes and requires every class to come out empty with label_err dropped. It also injects a sample and a second finalize pulse in the middle of an emission. A later finalize must show that class unchanged, and the first emission must still last exactly NCLS cycles.

// File: rtl/hdc_bundle_pkg.sv
// Shared types for the class trainer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package hdc_bundle_pkg;
    // Emission sequencer state.
    typedef enum logic {
        EM_IDLE = 1'b0,
        EM_RUN  = 1'b1
    } em_state_e;
endpackage

// File: rtl/hdc_class_bank.sv
// Per-class tally bank: one saturating sample counter and one saturating
// counter per hypervector bit. Assumes hit is already qualified (valid,
// in-range label, not emitting, no clear).
module hdc_class_bank #(
    parameter int DIM   = 32,
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 hit,
    input  logic [DIM-1:0]       vec,
    output logic [DIM*CNT_W-1:0] ones_flat,
    output logic [CNT_W-1:0]     n_cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    // Sample tally, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            n_cnt <= '0;
        else if (hit && n_cnt != CMAX)
            n_cnt <= n_cnt + 1'b1;
    end

    for (genvar j = 0; j < DIM; j++) begin : g_bit
        logic [CNT_W-1:0] c;
        // Ones counter for bit j, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                c <= '0;
            else if (hit && vec[j] && c != CMAX)
                c <= c + 1'b1;
        end
        assign ones_flat[j*CNT_W +: CNT_W] = c;
    end

    // R6
    tally_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> n_cnt >= $past(n_cnt));
    // R11
    tally_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> n_cnt == '0);
endmodule

// File: rtl/hdc_majority_bin.sv
// Bitwise majority threshold with tie vote. Purely combinational.
// Assumes the caller forces the result to zero for an empty class.
module hdc_majority_bin #(
    parameter int DIM   = 32,
    parameter int CNT_W = 4
) (
    input  logic [DIM*CNT_W-1:0] ones_flat,
    input  logic [CNT_W-1:0]     n_cnt,
    input  logic [DIM-1:0]       tie,
    output logic [DIM-1:0]       bits
);
    for (genvar j = 0; j < DIM; j++) begin : g_thr
        logic [CNT_W-1:0] c;
        logic             gt;
        logic             eq;
        assign c  = ones_flat[j*CNT_W +: CNT_W];
        // Compare 2c against n; a tie exists only for even n.
        assign gt = {c, 1'b0} > {1'b0, n_cnt};
        assign eq = {c, 1'b0} == {1'b0, n_cnt};
        assign bits[j] = gt | (eq & ~n_cnt[0] & tie[j]);
    end
endmodule

// File: rtl/hdc_emit_seq.sv
// Emission sequencer: after fin while idle, steps idx through 0..NCLS-1,
// one class per cycle. clr aborts it. Assumes NCLS >= 1.
module hdc_emit_seq
    import hdc_bundle_pkg::*;
#(
    parameter int NCLS  = 10,
    parameter int LBL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fin,
    output logic             busy,
    output logic [LBL_W-1:0] idx
);
    localparam logic [LBL_W-1:0] LAST = LBL_W'(NCLS - 1);

    em_state_e state;

    // Walk the classes in ascending order.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= EM_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                EM_IDLE: if (fin) begin
                    state <= EM_RUN;
                    idx   <= '0;
                end
                EM_RUN: if (idx == LAST) begin
                    state <= EM_IDLE;
                    idx   <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
                default: state <= EM_IDLE;
            endcase
        end
    end

    assign busy = (state == EM_RUN);
endmodule

// File: rtl/hdc_class_trainer.sv
// Majority bundling class trainer top. Accumulates labelled samples into
// per-class banks and, on fin, emits one binarized prototype per cycle.
// Assumes NCLS <= DIM (the tie pattern is a rotation by the class index).
module hdc_class_trainer #(
    parameter int             DIM      = 32,
    parameter int             NCLS     = 10,
    parameter int             CNT_W    = 4,
    parameter logic [DIM-1:0] TIE_SEED = 32'h9E3779B9,
    localparam int            LBL_W    = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [LBL_W-1:0] smp_label,
    input  logic [DIM-1:0]   smp_vec,
    input  logic             clr,
    input  logic             fin,
    output logic             proto_valid,
    output logic [LBL_W-1:0] proto_class,
    output logic [DIM-1:0]   proto_vec,
    output logic             proto_empty,
    output logic             label_err
);
    localparam int               SH_W   = $clog2(DIM) + 1;
    localparam logic [LBL_W:0]   NCLS_X = (LBL_W + 1)'(NCLS);
    localparam logic [LBL_W-1:0] LAST   = LBL_W'(NCLS - 1);

    logic                 busy;
    logic [LBL_W-1:0]     idx;
    logic                 in_range;
    logic                 take;
    logic [NCLS-1:0]      hit;
    logic [DIM*CNT_W-1:0] ones_all [NCLS];
    logic [CNT_W-1:0]     n_all    [NCLS];
    logic [DIM*CNT_W-1:0] ones_sel;
    logic [CNT_W-1:0]     n_sel;
    logic [2*DIM-1:0]     tie_dbl;
    logic [DIM-1:0]       tie;
    logic [DIM-1:0]       maj;

    assign in_range = {1'b0, smp_label} < NCLS_X;
    assign take     = smp_valid && in_range && !busy && !clr;

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        assign hit[k] = take && (smp_label == LBL_W'(k));
        hdc_class_bank #(.DIM(DIM), .CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .hit       (hit[k]),
            .vec       (smp_vec),
            .ones_flat (ones_all[k]),
            .n_cnt     (n_all[k])
        );
    end

    hdc_emit_seq #(.NCLS(NCLS), .LBL_W(LBL_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .fin   (fin),
        .busy  (busy),
        .idx   (idx)
    );

    // Select the bank of the class being emitted.
    always_comb begin
        ones_sel = '0;
        n_sel    = '0;
        for (int k = 0; k < NCLS; k++) begin
            if (idx == LBL_W'(k)) begin
                ones_sel = ones_all[k];
                n_sel    = n_all[k];
            end
        end
    end

    // Tie pattern: seed rotated left by the class index.
    assign tie_dbl = {TIE_SEED, TIE_SEED} >> (SH_W'(DIM) - SH_W'(idx));
    assign tie     = tie_dbl[DIM-1:0];

    hdc_majority_bin #(.DIM(DIM), .CNT_W(CNT_W)) u_maj (
        .ones_flat (ones_sel),
        .n_cnt     (n_sel),
        .tie       (tie),
        .bits      (maj)
    );

    // Sticky flag for samples naming a nonexistent class.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            label_err <= 1'b0;
        else if (smp_valid && !in_range)
            label_err <= 1'b1;
    end

    assign proto_valid = busy;
    assign proto_class = busy ? idx : '0;
    assign proto_empty = busy && (n_sel == '0);
    assign proto_vec   = (busy && n_sel != '0) ? maj : '0;

    // R7
    emit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin && !proto_valid && !clr |=> proto_valid && proto_class == '0);
    // R7
    emit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_valid && !clr && proto_class != LAST
        |=> proto_valid && proto_class == LBL_W'($past(proto_class) + 1'b1));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        label_err && !clr |=> label_err);
    // R11
    clr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !proto_valid && !label_err);
    // R5
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_empty |-> proto_valid && proto_vec == '0);
endmodule

// File: tb/hdc_class_trainer_test.sv
// Self-checking bench: a table of samples walked by one loop, then directed
// tests for reset, same-cycle events, saturation and clear.
module hdc_class_trainer_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          DIM   = 32;
    localparam int          NCLS  = 10;
    localparam int          CNT_W = 4;
    localparam int          LBL_W = 4;
    localparam int          CMAX  = (1 << CNT_W) - 1;
    localparam logic [31:0] SEED  = 32'h9E3779B9;
    localparam int          NSTIM = 12;
    // {label, vector}
    localparam logic [35:0] STIM [NSTIM] = '{
        {4'd0,  32'hF0F0_1234}, {4'd0, 32'hFF00_FF00}, {4'd0, 32'h0F0F_AAAA},
        {4'd1,  32'hAAAA_5555}, {4'd1, 32'h5555_AAAA},
        {4'd2,  32'hFFFF_0000}, {4'd2, 32'hFFFF_FFFF}, {4'd2, 32'h0000_FFFF},
        {4'd2,  32'h1234_5678}, {4'd3, 32'hDEAD_BEEF},
        {4'd13, 32'hFFFF_FFFF}, {4'd7, 32'h0000_0001}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [LBL_W-1:0] smp_label = '0;
    logic [DIM-1:0]   smp_vec = '0;
    logic             clr = 1'b0;
    logic             fin = 1'b0;
    logic             proto_valid;
    logic [LBL_W-1:0] proto_class;
    logic [DIM-1:0]   proto_vec;
    logic             proto_empty;
    logic             label_err;

    int n_chk = 0;
    int n_bad = 0;
    int m_n [NCLS];
    int m_c [NCLS][DIM];

    hdc_class_trainer #(.DIM(DIM), .NCLS(NCLS), .CNT_W(CNT_W), .TIE_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_label(smp_label),
        .smp_vec(smp_vec), .clr(clr), .fin(fin), .proto_valid(proto_valid),
        .proto_class(proto_class), .proto_vec(proto_vec),
        .proto_empty(proto_empty), .label_err(label_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int k = 0; k < NCLS; k++) begin
            m_n[k] = 0;
            for (int j = 0; j < DIM; j++) m_c[k][j] = 0;
        end
    endfunction

    function automatic void model_add(input int lbl, input logic [DIM-1:0] v);
        if (lbl < NCLS) begin
            if (m_n[lbl] < CMAX) m_n[lbl]++;
            for (int j = 0; j < DIM; j++)
                if (v[j] && m_c[lbl][j] < CMAX) m_c[lbl][j]++;
        end
    endfunction

    function automatic logic [DIM-1:0] tie_of(input int k);
        logic [DIM-1:0] r = SEED;
        for (int i = 0; i < k; i++) r = {r[DIM-2:0], r[DIM-1]};
        return r;
    endfunction

    function automatic logic [DIM-1:0] exp_vec(input int k);
        logic [DIM-1:0] r = '0;
        logic [DIM-1:0] t = tie_of(k);
        if (m_n[k] == 0) return '0;
        for (int j = 0; j < DIM; j++) begin
            if (2 * m_c[k][j] > m_n[k]) r[j] = 1'b1;
            else if (m_n[k] % 2 == 0 && 2 * m_c[k][j] == m_n[k]) r[j] = t[j];
        end
        return r;
    endfunction

    task automatic send(input int lbl, input logic [DIM-1:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_label = LBL_W'(lbl);
        smp_vec   = v;
        model_add(lbl, v);
    endtask

    // Finalize, optionally with a same-cycle sample and a mid-emission injection.
    task automatic run_fin(input bit with_s, input int lbl, input logic [DIM-1:0] v,
                           input bit inject);
        @(negedge clk);
        fin = 1'b1;
        smp_valid = with_s;
        smp_label = LBL_W'(lbl);
        smp_vec   = v;
        if (with_s) model_add(lbl, v);
        for (int k = 0; k < NCLS; k++) begin
            string tag;
            logic [DIM-1:0] e;
            @(negedge clk);
            e = exp_vec(k);
            if (with_s && k == lbl) tag = "R8";
            else if (m_n[k] == 0) tag = "R5";
            else if (m_n[k] % 2 == 1) tag = "R2 R3";
            else tag = "R2 R4";
            check(proto_valid && proto_class == LBL_W'(k) &&
                  proto_empty == (m_n[k] == 0) && proto_vec == e, tag,
                  {proto_valid, proto_empty, proto_class, proto_vec},
                  {1'b1, (m_n[k] == 0), LBL_W'(k), e});
            if (k == 0) begin
                fin = 1'b0;
                smp_valid = 1'b0;
            end
            if (inject && k == 3) begin
                fin = 1'b1;
                smp_valid = 1'b1;
                smp_label = 4'd5;
                smp_vec = '1;
            end
            if (inject && k == 4) begin
                fin = 1'b0;
                smp_valid = 1'b0;
            end
        end
        @(negedge clk);
        // R7 emission lasts exactly NCLS cycles; R9 fin inside it was ignored
        check(!proto_valid, "R7 R9", {63'd0, proto_valid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        model_clear();
        // R1 reset state, with inputs active during reset
        smp_valid = 1'b1;
        smp_label = 4'd13;
        fin = 1'b1;
        repeat (3) @(negedge clk);
        check(!proto_valid && !label_err, "R1", {proto_valid, label_err}, 64'd0);
        smp_valid = 1'b0;
        fin = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!proto_valid && !label_err, "R1", {proto_valid, label_err}, 64'd0);
        run_fin(1'b0, 0, '0, 1'b0);

        // Table walk
        for (int i = 0; i < NSTIM; i++)
            send(int'(STIM[i][35:32]), STIM[i][31:0]);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        // R10 out-of-range label flagged
        check(label_err, "R10", {63'd0, label_err}, 64'd1);

        // R8 sample with fin; R9 injection during emission
        run_fin(1'b1, 4, 32'hCAFE_F00D, 1'b1);
        // R9 second pass: class 5 still empty
        run_fin(1'b0, 0, '0, 1'b0);
        // R10 still sticky
        check(label_err, "R10", {63'd0, label_err}, 64'd1);

        // R11 clear together with a sample
        @(negedge clk);
        clr = 1'b1;
        smp_valid = 1'b1;
        smp_label = 4'd6;
        smp_vec = '1;
        @(negedge clk);
        clr = 1'b0;
        smp_valid = 1'b0;
        model_clear();
        check(!label_err, "R11", {63'd0, label_err}, 64'd0);
        run_fin(1'b0, 0, '0, 1'b0);

        // R6 saturation: 16 all-ones then one zero vector into class 9
        for (int i = 0; i < 16; i++) send(9, '1);
        send(9, '0);
        send(8, 32'h0000_FFFF);
        send(8, 32'h00FF_00FF);
        @(negedge clk);
        smp_valid = 1'b0;
        check(m_n[9] == CMAX, "R6", 64'(m_n[9]), 64'(CMAX));
        run_fin(1'b0, 0, '0, 1'b0);

        // R11 clear aborts a running emission
        @(negedge clk);
        fin = 1'b1;
        @(negedge clk);
        fin = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        check(!proto_valid, "R11", {63'd0, proto_valid}, 64'd0);
        run_fin(1'b0, 0, '0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule